// File: doc/BRIEF.md
# Store Set Memory Dependence Predictor

This block tells an out-of-order core whether a memory instruction should wait for an older store that is still in flight. Store and load PCs that have once been caught out of order are grouped into a shared set. The most recently fetched store of each set is remembered by its sequence number. A later instruction whose PC belongs to a set is then told which store to wait behind.

Two tables hold the prediction state, each entry with its own valid bit. The PC table maps a PC to a set number. The last-store table maps a set number to the sequence number of the youngest fetched store of that set. Ports are provided for:
- reporting ordering violations
- inserting fetched loads and stores
- looking up a dependence
- retiring issued stores
- squashing younger work
- wiping the whole predictor

The predictor also wipes itself after a programmable number of inserted memory operations, so that its sets do not grow until everything looks dependent.

Top module: `mdp_predictor`

## Requirements
- R1: After reset every entry of both tables is invalid, `lkp_vld_o` is 0 and `lkp_seq_o` is 0.
- R2: The PC table is indexed by `(pc >> PC_SHIFT) & (ID_ENTRIES-1)`, so PCs that differ only above those bits share an entry. A fresh set number is `(pc ^ (pc >> 10)) mod SET_ENTRIES` of the store PC.
- R3: A lookup presented with `lkp_vld_i` gives its result on `lkp_seq_o` with `lkp_vld_o` high one clock later. The result is 0 when the PC entry or the matching last-store entry is invalid, otherwise it is the stored sequence number. `lkp_seq_o` is 0 whenever `lkp_vld_o` is low.
- R4: A store insert writes its sequence number into its set's last-store entry and marks it valid only when the store PC's table entry is valid; otherwise it changes nothing.
- R5: A violation where neither PC entry is valid gives both PCs the fresh set number computed from the store PC and marks both valid.
- R6: A violation where exactly one of the two PC entries is valid copies that set number into the other entry and marks it valid.
- R7: A violation where both entries are valid with different set numbers writes the smaller of the two into both. Other PC entries are not changed.
- R8: A store issue invalidates its set's last-store entry only if that entry holds exactly the issuing sequence number.
- R9: A squash invalidates every last-store entry whose sequence number is greater than or equal to the squash sequence number.
- R10: A load insert changes no table state, but it counts as a memory operation.
- R11: Each insert (load or store) counts one memory operation. When an insert brings the count to `clr_period_i` (nonzero), both tables are fully invalidated at that clock edge, overriding that cycle's updates, and the count restarts from 0. A period of 0 disables the self-wipe.
- R12: `clear_i` invalidates both tables and restarts the operation count at the next edge.
- R13: A lookup sees the table state from before that cycle's updates. In the last-store table, a store insert in the same cycle as a squash or issue takes effect after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Wipe both tables and the operation count |
| clr_period_i | input | CNT_W | Memory operations between self-wipes, 0 = never |
| viol_vld_i | input | 1 | Violation report strobe |
| viol_st_pc_i | input | PC_W | PC of the older store in the violation |
| viol_ld_pc_i | input | PC_W | PC of the younger load in the violation |
| ins_vld_i | input | 1 | Memory operation insert strobe |
| ins_store_i | input | 1 | Inserted operation is a store (1) or load (0) |
| ins_pc_i | input | PC_W | PC of the inserted operation |
| ins_seq_i | input | 32 | Sequence number of the inserted operation, nonzero |
| lkp_vld_i | input | 1 | Lookup strobe |
| lkp_pc_i | input | PC_W | PC to look up |
| lkp_vld_o | output | 1 | Lookup result valid |
| lkp_seq_o | output | 32 | Predicted store sequence number, 0 = no dependence |
| iss_vld_i | input | 1 | Issue strobe |
| iss_store_i | input | 1 | Issued operation is a store |
| iss_pc_i | input | PC_W | PC of the issued operation |
| iss_seq_i | input | 32 | Sequence number of the issued operation |
| sq_vld_i | input | 1 | Squash strobe |
| sq_seq_i | input | 32 | Squash from this sequence number upward |

## Verification
The assertions rely on inserted stores never carrying sequence number 0, because 0 means "no dependence" on the lookup port. They also rely on the clear period not being changed while the count runs. The directed stimulus gives every store a nonzero sequence number and sets the period only just before a clear. Each scenario starts from a clear. Apart from the two same-cycle ordering cases, it drives one operation per cycle, and the PCs are chosen so that their table indices and set numbers can be worked out by hand.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int SEQ_W = 32;
  typedef logic [SEQ_W-1:0] seq_t;

  typedef enum logic [1:0] {
    VK_FRESH   = 2'd0,
    VK_FROM_ST = 2'd1,
    VK_FROM_LD = 2'd2,
    VK_MERGE   = 2'd3
  } viol_kind_e;

  localparam int RD_LKP = 0;
  localparam int RD_INS = 1;
  localparam int RD_ISS = 2;
  localparam int N_RD   = 3;
endpackage

// File: rtl/mdp_wipe_ctl.sv
module mdp_wipe_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             op_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             wipe_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic             hit;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit     = op_i && (period_i != '0) && (cnt_inc >= {1'b0, period_i});
  assign wipe_o  = clear_i || hit;

  always_ff @(posedge clk) begin
    if (rst || wipe_o) cnt_q <= '0;
    else if (op_i)     cnt_q <= cnt_inc[CNT_W-1:0];
  end

  p_wipe_restarts_count_r11: assert property (@(posedge clk) disable iff (rst)
    wipe_o |=> (cnt_q == '0));

  p_clear_restarts_count_r12: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/mdp_id_table.sv
module mdp_id_table
  import mdp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ENTRIES  = 64,
  parameter int SETS     = 16,
  parameter int PC_SHIFT = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wipe_i,
  input  logic                                 viol_vld_i,
  input  logic [PC_W-1:0]                      viol_st_pc_i,
  input  logic [PC_W-1:0]                      viol_ld_pc_i,
  input  logic [N_RD-1:0][PC_W-1:0]            rd_pc_i,
  output logic [N_RD-1:0][$clog2(SETS)-1:0]    rd_sid_o,
  output logic [N_RD-1:0]                      rd_ok_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int SID_W = $clog2(SETS);

  logic [SID_W-1:0]   sid_mem [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  function automatic logic [IDX_W-1:0] pc_index(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] sh;
    sh = pc >> PC_SHIFT;
    return sh[IDX_W-1:0];
  endfunction

  function automatic logic [SID_W-1:0] pc_fold(input logic [PC_W-1:0] pc);
    logic [PC_W-1:0] f;
    f = pc ^ (pc >> 10);
    return f[SID_W-1:0];
  endfunction

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    logic [IDX_W-1:0] ri;
    assign ri          = pc_index(rd_pc_i[r]);
    assign rd_sid_o[r] = sid_mem[ri];
    assign rd_ok_o[r]  = vld_q[ri];
  end

  logic [IDX_W-1:0] st_idx, ld_idx;
  logic [SID_W-1:0] st_sid, ld_sid, new_sid;
  logic             st_ok, ld_ok, wr_st, wr_ld;
  viol_kind_e       kind;

  assign st_idx = pc_index(viol_st_pc_i);
  assign ld_idx = pc_index(viol_ld_pc_i);
  assign st_sid = sid_mem[st_idx];
  assign ld_sid = sid_mem[ld_idx];
  assign st_ok  = vld_q[st_idx];
  assign ld_ok  = vld_q[ld_idx];

  always_comb begin
    unique case ({st_ok, ld_ok})
      2'b00:   kind = VK_FRESH;
      2'b10:   kind = VK_FROM_ST;
      2'b01:   kind = VK_FROM_LD;
      default: kind = VK_MERGE;
    endcase
    new_sid = '0;
    wr_st   = 1'b0;
    wr_ld   = 1'b0;
    unique case (kind)
      VK_FRESH: begin
        new_sid = pc_fold(viol_st_pc_i);
        wr_st   = 1'b1;
        wr_ld   = 1'b1;
      end
      VK_FROM_ST: begin
        new_sid = st_sid;
        wr_ld   = 1'b1;
      end
      VK_FROM_LD: begin
        new_sid = ld_sid;
        wr_st   = 1'b1;
      end
      default: begin
        new_sid = (st_sid < ld_sid) ? st_sid : ld_sid;
        wr_st   = (st_sid != new_sid);
        wr_ld   = (ld_sid != new_sid);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (viol_vld_i && wr_st) sid_mem[st_idx] <= new_sid;
    if (viol_vld_i && wr_ld) sid_mem[ld_idx] <= new_sid;
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_i) begin
      vld_q <= '0;
    end else if (viol_vld_i) begin
      vld_q[st_idx] <= 1'b1;
      vld_q[ld_idx] <= 1'b1;
    end
  end

  p_viol_marks_both_r5: assert property (@(posedge clk) disable iff (rst)
    (viol_vld_i && !wipe_i) |=> (vld_q[$past(st_idx)] && vld_q[$past(ld_idx)]));

  p_viol_joins_set_r6: assert property (@(posedge clk) disable iff (rst)
    (viol_vld_i && !wipe_i) |=> (sid_mem[$past(st_idx)] == sid_mem[$past(ld_idx)]));

  p_merge_not_larger_r7: assert property (@(posedge clk) disable iff (rst)
    (viol_vld_i && !wipe_i && st_ok && ld_ok) |=>
      (sid_mem[$past(st_idx)] <= $past(st_sid)) && (sid_mem[$past(ld_idx)] <= $past(ld_sid)));

  p_wipe_empties_r12: assert property (@(posedge clk) disable iff (rst)
    wipe_i |=> (vld_q == '0));
endmodule

// File: rtl/mdp_last_store.sv
module mdp_last_store
  import mdp_pkg::*;
#(
  parameter int SETS = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wipe_i,
  input  logic                    sq_vld_i,
  input  seq_t                    sq_seq_i,
  input  logic                    iss_vld_i,
  input  logic [$clog2(SETS)-1:0] iss_sid_i,
  input  seq_t                    iss_seq_i,
  input  logic                    ins_vld_i,
  input  logic [$clog2(SETS)-1:0] ins_sid_i,
  input  seq_t                    ins_seq_i,
  input  logic [$clog2(SETS)-1:0] rd_sid_i,
  output logic                    rd_ok_o,
  output seq_t                    rd_seq_o
);
  localparam int SID_W = $clog2(SETS);

  seq_t            seq_q [SETS];
  logic [SETS-1:0] vld_q;
  logic [SETS-1:0] kill;
  logic [SETS-1:0] load;

  for (genvar e = 0; e < SETS; e++) begin : g_ent
    logic sq_hit, iss_hit;
    assign sq_hit  = sq_vld_i && (seq_q[e] >= sq_seq_i);
    assign iss_hit = iss_vld_i && (iss_sid_i == SID_W'(e)) && (seq_q[e] == iss_seq_i);
    assign kill[e] = vld_q[e] && (sq_hit || iss_hit);
    assign load[e] = ins_vld_i && (ins_sid_i == SID_W'(e));

    p_squash_drops_r9: assert property (@(posedge clk) disable iff (rst)
      (sq_vld_i && vld_q[e] && (seq_q[e] >= sq_seq_i) && !load[e]) |=> !vld_q[e]);

    p_insert_wins_r13: assert property (@(posedge clk) disable iff (rst)
      (load[e] && !wipe_i) |=> (vld_q[e] && (seq_q[e] == $past(ins_seq_i))));
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < SETS; e++) begin
      if (load[e]) seq_q[e] <= ins_seq_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe_i) begin
      vld_q <= '0;
    end else begin
      for (int e = 0; e < SETS; e++) begin
        if (load[e])      vld_q[e] <= 1'b1;
        else if (kill[e]) vld_q[e] <= 1'b0;
      end
    end
  end

  assign rd_ok_o  = vld_q[rd_sid_i];
  assign rd_seq_o = seq_q[rd_sid_i];

  p_wipe_empties_r11: assert property (@(posedge clk) disable iff (rst)
    wipe_i |=> (vld_q == '0));
endmodule

// File: rtl/mdp_predictor.sv
module mdp_predictor
  import mdp_pkg::*;
#(
  parameter int PC_W        = 32,
  parameter int ID_ENTRIES  = 64,
  parameter int SET_ENTRIES = 16,
  parameter int PC_SHIFT    = 2,
  parameter int CNT_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  clr_period_i,
  input  logic              viol_vld_i,
  input  logic [PC_W-1:0]   viol_st_pc_i,
  input  logic [PC_W-1:0]   viol_ld_pc_i,
  input  logic              ins_vld_i,
  input  logic              ins_store_i,
  input  logic [PC_W-1:0]   ins_pc_i,
  input  logic [SEQ_W-1:0]  ins_seq_i,
  input  logic              lkp_vld_i,
  input  logic [PC_W-1:0]   lkp_pc_i,
  output logic              lkp_vld_o,
  output logic [SEQ_W-1:0]  lkp_seq_o,
  input  logic              iss_vld_i,
  input  logic              iss_store_i,
  input  logic [PC_W-1:0]   iss_pc_i,
  input  logic [SEQ_W-1:0]  iss_seq_i,
  input  logic              sq_vld_i,
  input  logic [SEQ_W-1:0]  sq_seq_i
);
  localparam int SID_W = $clog2(SET_ENTRIES);

  logic                         wipe;
  logic [N_RD-1:0][PC_W-1:0]    rd_pc;
  logic [N_RD-1:0][SID_W-1:0]   rd_sid;
  logic [N_RD-1:0]              rd_ok;
  logic                         ls_ok;
  seq_t                         ls_seq;

  assign rd_pc[RD_LKP] = lkp_pc_i;
  assign rd_pc[RD_INS] = ins_pc_i;
  assign rd_pc[RD_ISS] = iss_pc_i;

  mdp_wipe_ctl #(.CNT_W(CNT_W)) u_wipe (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (clear_i),
    .op_i     (ins_vld_i),
    .period_i (clr_period_i),
    .wipe_o   (wipe)
  );

  mdp_id_table #(
    .PC_W     (PC_W),
    .ENTRIES  (ID_ENTRIES),
    .SETS     (SET_ENTRIES),
    .PC_SHIFT (PC_SHIFT)
  ) u_ids (
    .clk          (clk),
    .rst          (rst),
    .wipe_i       (wipe),
    .viol_vld_i   (viol_vld_i),
    .viol_st_pc_i (viol_st_pc_i),
    .viol_ld_pc_i (viol_ld_pc_i),
    .rd_pc_i      (rd_pc),
    .rd_sid_o     (rd_sid),
    .rd_ok_o      (rd_ok)
  );

  mdp_last_store #(.SETS(SET_ENTRIES)) u_last (
    .clk       (clk),
    .rst       (rst),
    .wipe_i    (wipe),
    .sq_vld_i  (sq_vld_i),
    .sq_seq_i  (sq_seq_i),
    .iss_vld_i (iss_vld_i && iss_store_i && rd_ok[RD_ISS]),
    .iss_sid_i (rd_sid[RD_ISS]),
    .iss_seq_i (iss_seq_i),
    .ins_vld_i (ins_vld_i && ins_store_i && rd_ok[RD_INS]),
    .ins_sid_i (rd_sid[RD_INS]),
    .ins_seq_i (ins_seq_i),
    .rd_sid_i  (rd_sid[RD_LKP]),
    .rd_ok_o   (ls_ok),
    .rd_seq_o  (ls_seq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_vld_o <= 1'b0;
      lkp_seq_o <= '0;
    end else begin
      lkp_vld_o <= lkp_vld_i;
      lkp_seq_o <= (lkp_vld_i && rd_ok[RD_LKP] && ls_ok) ? ls_seq : '0;
    end
  end

  p_idle_result_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !lkp_vld_o |-> (lkp_seq_o == '0));

  p_lookup_latency_r3: assert property (@(posedge clk) disable iff (rst)
    lkp_vld_i |=> lkp_vld_o);

  p_store_seq_nonzero_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_vld_i && ins_store_i) |-> (ins_seq_i != '0));

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!lkp_vld_o && lkp_seq_o == '0));
endmodule

// File: tb/mdp_predictor_bench.sv
module mdp_predictor_bench;
  localparam int PC_W  = 32;
  localparam int CNT_W = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clear_i = 1'b0;
  logic [CNT_W-1:0]  clr_period_i = '0;
  logic              viol_vld_i = 1'b0;
  logic [PC_W-1:0]   viol_st_pc_i = '0, viol_ld_pc_i = '0;
  logic              ins_vld_i = 1'b0, ins_store_i = 1'b0;
  logic [PC_W-1:0]   ins_pc_i = '0;
  logic [31:0]       ins_seq_i = '0;
  logic              lkp_vld_i = 1'b0;
  logic [PC_W-1:0]   lkp_pc_i = '0;
  logic              lkp_vld_o;
  logic [31:0]       lkp_seq_o;
  logic              iss_vld_i = 1'b0, iss_store_i = 1'b0;
  logic [PC_W-1:0]   iss_pc_i = '0;
  logic [31:0]       iss_seq_i = '0;
  logic              sq_vld_i = 1'b0;
  logic [31:0]       sq_seq_i = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  mdp_predictor u_mdp_predictor (
    .clk, .rst, .clear_i, .clr_period_i,
    .viol_vld_i, .viol_st_pc_i, .viol_ld_pc_i,
    .ins_vld_i, .ins_store_i, .ins_pc_i, .ins_seq_i,
    .lkp_vld_i, .lkp_pc_i, .lkp_vld_o, .lkp_seq_o,
    .iss_vld_i, .iss_store_i, .iss_pc_i, .iss_seq_i,
    .sq_vld_i, .sq_seq_i
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    clear_i = 0; viol_vld_i = 0; ins_vld_i = 0; lkp_vld_i = 0; iss_vld_i = 0; sq_vld_i = 0;
  endtask

  task automatic do_clear();
    @(negedge clk); clear_i = 1; idle();
  endtask

  task automatic do_viol(input logic [31:0] st, input logic [31:0] ld);
    @(negedge clk); viol_vld_i = 1; viol_st_pc_i = st; viol_ld_pc_i = ld; idle();
  endtask

  task automatic do_ins(input logic st, input logic [31:0] pc, input logic [31:0] seq);
    @(negedge clk); ins_vld_i = 1; ins_store_i = st; ins_pc_i = pc; ins_seq_i = seq; idle();
  endtask

  task automatic do_iss(input logic [31:0] pc, input logic [31:0] seq);
    @(negedge clk); iss_vld_i = 1; iss_store_i = 1; iss_pc_i = pc; iss_seq_i = seq; idle();
  endtask

  task automatic do_sq(input logic [31:0] seq);
    @(negedge clk); sq_vld_i = 1; sq_seq_i = seq; idle();
  endtask

  task automatic look(input string req, input logic [31:0] pc, input logic [31:0] exp);
    @(negedge clk); lkp_vld_i = 1; lkp_pc_i = pc; idle();
    check(req, {31'd0, lkp_vld_o}, 32'd1);
    check(req, lkp_seq_o, exp);
  endtask

  // PCs below 0x100 with step 4: index = pc/4, fresh set = pc & 15.
  task automatic t_reset();
    check("R1 vld", {31'd0, lkp_vld_o}, 0);
    check("R1 seq", lkp_seq_o, 0);
    look("R1", 32'h40, 0);
  endtask

  task automatic t_unmapped();
    do_clear();
    do_ins(1, 32'h44, 5);
    look("R4 store without mapping", 32'h44, 0);
    look("R3 unmapped pc", 32'h48, 0);
  endtask

  task automatic t_fresh();
    do_clear();
    do_viol(32'h08, 32'h0C);
    look("R3 mapped but no store", 32'h0C, 0);
    do_ins(1, 32'h08, 10);
    look("R5 load", 32'h0C, 10);
    look("R5 store", 32'h08, 10);
    do_viol(32'h28, 32'h2C);
    do_ins(1, 32'h28, 20);
    look("R2 fold shares set", 32'h0C, 20);
    look("R2 index alias", 32'h10C, 20);
  endtask

  task automatic t_copy();
    do_clear();
    do_viol(32'h10, 32'h14);
    do_viol(32'h18, 32'h14);
    do_ins(1, 32'h18, 30);
    look("R6 from load", 32'h14, 30);
    look("R6 from load peer", 32'h10, 30);
    do_viol(32'h10, 32'h20);
    look("R6 from store", 32'h20, 30);
  endtask

  task automatic t_merge();
    do_clear();
    do_viol(32'h30, 32'h34);
    do_viol(32'h38, 32'h3C);
    do_viol(32'h38, 32'h34);
    do_ins(1, 32'h30, 40);
    look("R7 smaller wins", 32'h38, 40);
    look("R7 other pc untouched", 32'h3C, 0);
  endtask

  task automatic t_issue();
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_ins(1, 32'h08, 50);
    do_iss(32'h08, 49);
    look("R8 other seq", 32'h0C, 50);
    do_iss(32'h08, 50);
    look("R8 matching seq", 32'h0C, 0);
  endtask

  task automatic t_squash();
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_viol(32'h10, 32'h14);
    do_ins(1, 32'h08, 100);
    do_ins(1, 32'h10, 200);
    do_sq(150);
    look("R9 older kept", 32'h0C, 100);
    look("R9 younger dropped", 32'h14, 0);
    do_sq(100);
    look("R9 equal dropped", 32'h0C, 0);
  endtask

  task automatic t_load();
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_ins(1, 32'h08, 60);
    do_ins(0, 32'h0C, 70);
    look("R10 load insert", 32'h0C, 60);
  endtask

  task automatic t_wipe();
    clr_period_i = 4;
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_ins(1, 32'h08, 11);
    do_ins(0, 32'h0C, 12);
    do_ins(0, 32'h0C, 13);
    look("R11 before period", 32'h0C, 11);
    do_ins(0, 32'h0C, 14);
    look("R11 after period", 32'h0C, 0);
    do_ins(1, 32'h08, 15);
    look("R11 mapping wiped", 32'h08, 0);
    clr_period_i = 0;
    do_clear();
    do_viol(32'h08, 32'h0C);
    for (int i = 0; i < 8; i++) do_ins(1, 32'h08, 32'd20 + i);
    look("R11 period zero", 32'h0C, 27);
  endtask

  task automatic t_clear();
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_ins(1, 32'h08, 33);
    do_clear();
    look("R12 store entry", 32'h0C, 0);
    do_ins(1, 32'h08, 34);
    look("R12 mapping", 32'h0C, 0);
  endtask

  task automatic t_same_cycle();
    do_clear();
    do_viol(32'h08, 32'h0C);
    do_ins(1, 32'h08, 80);
    @(negedge clk);
    ins_vld_i = 1; ins_store_i = 1; ins_pc_i = 32'h08; ins_seq_i = 90;
    lkp_vld_i = 1; lkp_pc_i = 32'h0C;
    idle();
    check("R13 lookup sees old", lkp_seq_o, 80);
    look("R13 insert landed", 32'h0C, 90);
    @(negedge clk);
    sq_vld_i = 1; sq_seq_i = 85;
    ins_vld_i = 1; ins_store_i = 1; ins_pc_i = 32'h08; ins_seq_i = 95;
    idle();
    look("R13 insert after squash", 32'h0C, 95);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_unmapped();
    t_fresh();
    t_copy();
    t_merge();
    t_issue();
    t_squash();
    t_load();
    t_wipe();
    t_clear();
    t_same_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule